// File: doc/BRIEF.md
# Interrupt Vector Offset Generator

This block works out where the processor jumps when it takes an external interrupt. It holds a small interrupt-control register, whose 5-bit spacing field sets the distance between interrupt vectors in units of 32 bytes. It also holds a programmable exception base register. From these registers and from the state the core presents at the moment it takes the interrupt, it forms a vector offset and a full vector address. The core presents the vector-enable bit, the boot-vector bit, the eight pending lines, the eight mask bits and the vectoring mode.

There are three outcomes. With vectoring disabled, the block gives the single general offset 0x180. With vectoring enabled but overridden by the boot-vector bit or by a zero spacing, it gives the flat offset 0x200. Otherwise the offset is 0x200 plus a vector number times the spacing. The vector number comes from one of two sources. In internal mode it is the index of the highest enabled pending line, found by priority encoding. In external-controller mode it is the pending field taken as a raw 8-bit number. The core pulses a take strobe, and the result appears on registered outputs one clock later.

Top module: `irq_vector_gen`

## Requirements
- R1: When the take strobe is sampled with the vector-enable input low, the next vecOffset is 0x180.
- R2: With vector-enable high and the boot-vector input high, the next vecOffset is 0x200, whatever the spacing and pending state.
- R3: With vector-enable high, boot-vector low and a spacing field of zero, the next vecOffset is 0x200.
- R4: In the vectored case, vecOffset = 0x200 + vector × spacing × 32, where spacing is bits 9:5 of the interrupt-control register.
- R5: When extCtrlMode is high, the vector number is pendBits read as an unsigned number, and maskBits has no effect.
- R6: When extCtrlMode is low, the vector number is the index (0 to 7) of the highest set bit of pendBits AND maskBits, or 0 when no such bit is set.
- R7: A control write changes only bits 9:5 of the control register (mask 0x0000_03E0), loads them from wrData, and leaves all other bits as they were.
- R8: A base write changes only bits 29:12 of the base register (mask 0x3FFF_F000) and leaves all other bits as they were.
- R9: vecAddr equals the base register value at the take edge plus the offset computed at that edge.
- R10: vecOffset and vecAddr change only on a clock edge at which takeIrq is high; otherwise they hold their value.
- R11: After reset, both registers and both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the interrupt-control register |
| baseWrEn | input | 1 | Write strobe for the exception base register |
| wrData | input | 32 | Write data for either register |
| causeVecEn | input | 1 | Vector-enable bit from the cause register |
| statusBev | input | 1 | Boot-vector bit from the status register |
| extCtrlMode | input | 1 | 1 = vector number comes from the external controller |
| pendBits | input | 8 | Pending interrupt lines |
| maskBits | input | 8 | Interrupt mask bits |
| takeIrq | input | 1 | Strobe: the core is taking an external interrupt |
| ctlRegQ | output | 32 | Current interrupt-control register value |
| baseRegQ | output | 32 | Current exception base register value |
| vecOffset | output | 32 | Registered vector offset |
| vecAddr | output | 32 | Registered vector address (base + offset) |

## Verification
The bench builds the block with its default parameters: eight pending lines, a 5-bit spacing field at bit 5 and a 32-bit address. These values make the largest offset, 0x3DE20 (external vector 255 with spacing 31), reachable and checkable. They also allow every one of the 31 nonzero spacings to be swept with random pending and mask patterns in both modes. Hand-computed table rows cover the fallback paths, an empty masked set and the highest- and lowest-priority lines.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    PATH_GEN  = 2'd0,
    PATH_FLAT = 2'd1,
    PATH_VEC  = 2'd2
  } path_e;

  typedef struct packed {
    logic  loadCtl;
    logic  loadBase;
    logic  loadOut;
    logic  useExt;
    path_e path;
  } ctrl_strb_t;

endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic       ctlWrEn,
  input  logic       baseWrEn,
  input  logic       takeIrq,
  input  logic       causeVecEn,
  input  logic       statusBev,
  input  logic       extCtrlMode,
  input  logic       spacingZero,
  output ctrl_strb_t strb
);

  path_e pathSel;

  always_comb begin
    if (!causeVecEn)                    pathSel = PATH_GEN;
    else if (statusBev || spacingZero)  pathSel = PATH_FLAT;
    else                                pathSel = PATH_VEC;
  end

  always_comb begin
    strb.loadCtl  = ctlWrEn;
    strb.loadBase = baseWrEn;
    strb.loadOut  = takeIrq;
    strb.useExt   = extCtrlMode;
    strb.path     = pathSel;
  end

endmodule

// File: rtl/irq_vec_dp.sv
module irq_vec_dp
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PEND_W     = 8,
  parameter int SPC_W      = 5,
  parameter int SPC_LSB    = 5,
  parameter int BASE_LSB   = 12,
  parameter int BASE_MSB   = 29,
  parameter int UNIT_SHIFT = 5,
  parameter int GEN_OFF    = 'h180,
  parameter int VEC_OFF    = 'h200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [PEND_W-1:0] pendBits,
  input  logic [PEND_W-1:0] maskBits,
  output logic              spacingZero,
  output logic [ADDR_W-1:0] ctlRegQ,
  output logic [ADDR_W-1:0] baseRegQ,
  output logic [ADDR_W-1:0] vecOffset,
  output logic [ADDR_W-1:0] vecAddr
);

  localparam int IDX_W = (PEND_W > 1) ? $clog2(PEND_W) : 1;
  localparam logic [ADDR_W-1:0] ONES      = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] CTL_MASK  =
      {{(ADDR_W-SPC_W){1'b0}}, {SPC_W{1'b1}}} << SPC_LSB;
  localparam logic [ADDR_W-1:0] BASE_MASK =
      (ONES >> (ADDR_W-1-BASE_MSB)) & (ONES << BASE_LSB);
  localparam logic [ADDR_W-1:0] GEN_OFFSET = ADDR_W'(GEN_OFF);
  localparam logic [ADDR_W-1:0] VEC_OFFSET = ADDR_W'(VEC_OFF);

  logic [ADDR_W-1:0] ctlReg, baseReg;
  logic [ADDR_W-1:0] offReg, addrReg;
  logic [SPC_W-1:0]  spacing;
  logic [PEND_W-1:0] maskedPend;
  logic [PEND_W-1:0] topHit;
  logic [IDX_W-1:0]  intVec;
  logic [PEND_W-1:0] vecNum;
  logic [ADDR_W-1:0] stepProd;
  logic [ADDR_W-1:0] nextOff;
  logic [ADDR_W-1:0] nextAddr;

  // Register file: masked writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      baseReg <= '0;
    end else begin
      if (strb.loadCtl)
        ctlReg <= (ctlReg & ~CTL_MASK) | (wrData & CTL_MASK);
      if (strb.loadBase)
        baseReg <= (baseReg & ~BASE_MASK) | (wrData & BASE_MASK);
    end
  end

  assign spacing     = ctlReg[SPC_LSB +: SPC_W];
  assign spacingZero = (spacing == '0);
  assign maskedPend  = pendBits & maskBits;

  // Priority encoder: a line is the top hit when nothing above it is set
  for (genvar i = 0; i < PEND_W; i++) begin : g_top
    assign topHit[i] = maskedPend[i] & ~(|(maskedPend >> (i + 1)));
  end

  always_comb begin
    intVec = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (topHit[i]) intVec = IDX_W'(i);
    end
  end

  assign vecNum   = strb.useExt ? pendBits : PEND_W'(intVec);
  assign stepProd = ADDR_W'(vecNum) * ADDR_W'(spacing);

  always_comb begin
    unique case (strb.path)
      PATH_GEN:  nextOff = GEN_OFFSET;
      PATH_FLAT: nextOff = VEC_OFFSET;
      default:   nextOff = VEC_OFFSET + (stepProd << UNIT_SHIFT);
    endcase
  end

  assign nextAddr = baseReg + nextOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg  <= '0;
      addrReg <= '0;
    end else if (strb.loadOut) begin
      offReg  <= nextOff;
      addrReg <= nextAddr;
    end
  end

  assign ctlRegQ   = ctlReg;
  assign baseRegQ  = baseReg;
  assign vecOffset = offReg;
  assign vecAddr   = addrReg;

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PEND_W   = 8,
  parameter int SPC_W    = 5,
  parameter int SPC_LSB  = 5,
  parameter int BASE_LSB = 12,
  parameter int BASE_MSB = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              causeVecEn,
  input  logic              statusBev,
  input  logic              extCtrlMode,
  input  logic [PEND_W-1:0] pendBits,
  input  logic [PEND_W-1:0] maskBits,
  input  logic              takeIrq,
  output logic [ADDR_W-1:0] ctlRegQ,
  output logic [ADDR_W-1:0] baseRegQ,
  output logic [ADDR_W-1:0] vecOffset,
  output logic [ADDR_W-1:0] vecAddr
);

  ctrl_strb_t strb;
  logic       spacingZero;

  irq_vec_ctrl u_ctrl (
    .ctlWrEn    (ctlWrEn),
    .baseWrEn   (baseWrEn),
    .takeIrq    (takeIrq),
    .causeVecEn (causeVecEn),
    .statusBev  (statusBev),
    .extCtrlMode(extCtrlMode),
    .spacingZero(spacingZero),
    .strb       (strb)
  );

  irq_vec_dp #(
    .ADDR_W  (ADDR_W),
    .PEND_W  (PEND_W),
    .SPC_W   (SPC_W),
    .SPC_LSB (SPC_LSB),
    .BASE_LSB(BASE_LSB),
    .BASE_MSB(BASE_MSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .pendBits   (pendBits),
    .maskBits   (maskBits),
    .spacingZero(spacingZero),
    .ctlRegQ    (ctlRegQ),
    .baseRegQ   (baseRegQ),
    .vecOffset  (vecOffset),
    .vecAddr    (vecAddr)
  );

endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int ADDR_W   = 32,
  parameter int SPC_W    = 5,
  parameter int SPC_LSB  = 5,
  parameter int BASE_LSB = 12,
  parameter int BASE_MSB = 29
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic              baseWrEn,
  input logic [ADDR_W-1:0] wrData,
  input logic              causeVecEn,
  input logic              statusBev,
  input logic              takeIrq,
  input logic [ADDR_W-1:0] ctlRegQ,
  input logic [ADDR_W-1:0] baseRegQ,
  input logic [ADDR_W-1:0] vecOffset,
  input logic [ADDR_W-1:0] vecAddr
);

  localparam logic [ADDR_W-1:0] ONES  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] CMASK =
      {{(ADDR_W-SPC_W){1'b0}}, {SPC_W{1'b1}}} << SPC_LSB;
  localparam logic [ADDR_W-1:0] BMASK =
      (ONES >> (ADDR_W-1-BASE_MSB)) & (ONES << BASE_LSB);

  p_gen_offset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && !causeVecEn) |=> (vecOffset == ADDR_W'(32'h180)));

  p_bev_flat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && causeVecEn && statusBev) |=> (vecOffset == ADDR_W'(32'h200)));

  p_zero_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && causeVecEn && (ctlRegQ[SPC_LSB +: SPC_W] == '0))
      |=> (vecOffset == ADDR_W'(32'h200)));

  p_vec_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && causeVecEn) |=> (vecOffset >= ADDR_W'(32'h200)) && (vecOffset[4:0] == 5'd0));

  p_ctl_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> ((ctlRegQ & CMASK) == ($past(wrData) & CMASK))
             && ((ctlRegQ & ~CMASK) == ($past(ctlRegQ) & ~CMASK)));

  p_base_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> ((baseRegQ & BMASK) == ($past(wrData) & BMASK))
              && ((baseRegQ & ~BMASK) == ($past(baseRegQ) & ~BMASK)));

  p_addr_sum_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> (vecAddr == $past(baseRegQ) + vecOffset));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |=> ($stable(vecOffset) && $stable(vecAddr)));

endmodule

bind irq_vector_gen irq_vec_chk #(
  .ADDR_W  (ADDR_W),
  .SPC_W   (SPC_W),
  .SPC_LSB (SPC_LSB),
  .BASE_LSB(BASE_LSB),
  .BASE_MSB(BASE_MSB)
) u_chk (.*);

// File: tb/irq_vector_gen_bench.sv
module irq_vector_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0, baseWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        causeVecEn = 1'b0, statusBev = 1'b0, extCtrlMode = 1'b0;
  logic [7:0]  pendBits = '0, maskBits = '0;
  logic        takeIrq = 1'b0;
  logic [31:0] ctlRegQ, baseRegQ, vecOffset, vecAddr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  irq_vector_gen u_irq_vector_gen (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .baseWrEn(baseWrEn),
    .wrData(wrData), .causeVecEn(causeVecEn), .statusBev(statusBev),
    .extCtrlMode(extCtrlMode), .pendBits(pendBits), .maskBits(maskBits),
    .takeIrq(takeIrq), .ctlRegQ(ctlRegQ), .baseRegQ(baseRegQ),
    .vecOffset(vecOffset), .vecAddr(vecAddr)
  );

  typedef struct packed {
    logic        en;
    logic        bev;
    logic        ext;
    logic [4:0]  spc;
    logic [7:0]  pend;
    logic [7:0]  mask;
    logic [31:0] off;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b0, 5'd3,  8'hFF, 8'hFF, 32'h180},    // R1
    '{1'b1, 1'b1, 1'b0, 5'd3,  8'h80, 8'hFF, 32'h200},    // R2
    '{1'b1, 1'b0, 1'b0, 5'd0,  8'h80, 8'h80, 32'h200},    // R3
    '{1'b1, 1'b0, 1'b0, 5'd1,  8'h80, 8'hFF, 32'h2E0},    // R4 R6 top line
    '{1'b1, 1'b0, 1'b0, 5'd2,  8'h0C, 8'h04, 32'h280},    // R6 mask removes bit 3
    '{1'b1, 1'b0, 1'b0, 5'd31, 8'hFF, 8'h00, 32'h200},    // R6 empty set
    '{1'b1, 1'b0, 1'b0, 5'd4,  8'h01, 8'h01, 32'h200},    // R6 line 0
    '{1'b1, 1'b0, 1'b1, 5'd1,  8'h05, 8'h00, 32'h2A0},    // R5 raw value
    '{1'b1, 1'b0, 1'b1, 5'd31, 8'hFF, 8'h00, 32'h3DE20},  // R5 largest
    '{1'b1, 1'b0, 1'b1, 5'd16, 8'h00, 8'hFF, 32'h200},    // R5 zero vector
    '{1'b1, 1'b0, 1'b0, 5'd16, 8'h30, 8'hF0, 32'hC00}     // R4 wide spacing
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [31:0] d);
    @(negedge clk); ctlWrEn = 1'b1; wrData = d;
    @(negedge clk); ctlWrEn = 1'b0; wrData = '0;
  endtask

  task automatic wrBase(input logic [31:0] d);
    @(negedge clk); baseWrEn = 1'b1; wrData = d;
    @(negedge clk); baseWrEn = 1'b0; wrData = '0;
  endtask

  task automatic take(input logic en, input logic bev, input logic ext,
                      input logic [7:0] pend, input logic [7:0] mask);
    @(negedge clk);
    causeVecEn = en; statusBev = bev; extCtrlMode = ext;
    pendBits = pend; maskBits = mask; takeIrq = 1'b1;
    @(negedge clk);
    takeIrq = 1'b0;
  endtask

  function automatic logic [31:0] refOff(input logic en, input logic bev, input logic ext,
                                         input logic [4:0] spc, input logic [7:0] pend,
                                         input logic [7:0] mask);
    logic [31:0] v;
    logic [7:0]  m;
    if (!en) return 32'h180;
    if (bev || spc == 5'd0) return 32'h200;
    if (ext) v = {24'd0, pend};
    else begin
      m = pend & mask;
      v = 0;
      for (int b = 7; b >= 0; b--) if (m[b] && v == 0) v = b;
    end
    return 32'h200 + v * spc * 32;
  endfunction

  initial begin
    logic [31:0] holdOff, holdAddr;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 ctlRegQ", ctlRegQ, 32'h0);
    check("R11 baseRegQ", baseRegQ, 32'h0);
    check("R11 vecOffset", vecOffset, 32'h0);
    check("R11 vecAddr", vecAddr, 32'h0);
    rstN = 1'b1;

    // R7 / R8: write masks
    wrCtl(32'hFFFF_FFFF);
    check("R7 ctl all ones", ctlRegQ, 32'h0000_03E0);
    wrCtl(32'hFFFF_FC1F);
    check("R7 ctl field cleared", ctlRegQ, 32'h0000_0000);
    wrBase(32'hFFFF_FFFF);
    check("R8 base all ones", baseRegQ, 32'h3FFF_F000);
    wrBase(32'h8000_3ABC);
    check("R8 base partial", baseRegQ, 32'h0000_3000);

    // Table walk (base = 0x3000)
    for (int k = 0; k < NV; k++) begin
      wrCtl({22'h3FFFFF, TBL[k].spc, 5'h1F});
      take(TBL[k].en, TBL[k].bev, TBL[k].ext, TBL[k].pend, TBL[k].mask);
      check($sformatf("R1-6 table row %0d offset", k), vecOffset, TBL[k].off);
      check($sformatf("R9 table row %0d addr", k), vecAddr, 32'h3000 + TBL[k].off);
    end

    // R10: outputs hold without the take strobe
    holdOff = vecOffset; holdAddr = vecAddr;
    @(negedge clk);
    causeVecEn = 1'b0; pendBits = 8'h55; maskBits = 8'hAA; extCtrlMode = 1'b0;
    wrBase(32'h1000_0000);
    repeat (3) @(negedge clk);
    check("R10 offset held", vecOffset, holdOff);
    check("R10 addr held", vecAddr, holdAddr);
    take(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R9 new base", vecAddr, 32'h1000_0180);

    // Sweep all nonzero spacings, both modes
    for (int s = 1; s < 32; s++) begin
      wrCtl(32'(s) << 5);
      for (int r = 0; r < 3; r++) begin
        logic [7:0] p, m;
        logic e;
        p = 8'($urandom); m = 8'($urandom); e = (r == 2);
        take(1'b1, 1'b0, e, p, m);
        check(e ? "R5 sweep" : "R6 R4 sweep", vecOffset,
              refOff(1'b1, 1'b0, e, 5'(s), p, m));
        check("R9 sweep addr", vecAddr, 32'h1000_0000 + refOff(1'b1, 1'b0, e, 5'(s), p, m));
      end
    end

    // R2 with a nonzero spacing and full pending
    take(1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    check("R2 boot override", vecOffset, 32'h200);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule